// File: doc/BRIEF.md
# Shared Buffer Completion Handshake

This block sits on the consumer side of a buffer in shared RAM that another agent fills. It decides when that buffer is finished and safe to process, and it hands over a trustworthy copy of the buffer's final word. It reports a buffer as finished only after it has read two matching values in a row, so a word caught halfway through an update is never reported.

Completion can be detected in one of two ways, chosen per run by a mode input. In sentinel mode the final word is expected to hold a reserved marker value. The block polls that word until it reads anything other than the marker. Such a change is safe to detect even while the word is being written, because every new value differs from the marker. In flag mode the block issues no RAM reads until an external ready bit goes high. In both modes it then re-reads the final word until two consecutive reads agree. A budget of tolerated disagreements bounds this confirmation step, and an error is raised when the budget runs out.

A start pulse arms the controller. When the run uses sentinel mode, the start also produces a request that the filling side write the marker back, ready for the next fill.

Top module: `bufhs_ctrl`

## Requirements
- R1: After reset, busy, buf_done, stable_err, rd_en and rearm_req are all 0.
- R2: A start pulse while busy is 0 is accepted, and busy is 1 from the next cycle. A start pulse while busy is 1 is ignored: it produces no rearm_req and does not change the run in progress.
- R3: rearm_req is a single-cycle pulse in the cycle after an accepted start with use_flag=0 (sentinel mode). It stays 0 after an accepted start with use_flag=1 (flag mode).
- R4: In sentinel mode the block keeps re-reading the final word while that word equals SENTINEL. The first read that differs from SENTINEL starts confirmation, and that value becomes the reference.
- R5: In flag mode, rd_en stays 0 while ready_flag is 0. Once ready_flag is seen high, the block starts confirmation reads, and the first read becomes the reference.
- R6: When a confirmation read equals the previous read, stable_val takes that value and buf_done is 1 for exactly one cycle. Then busy returns to 0.
- R7: Up to MAX_RETRY disagreeing confirmation reads are tolerated, and each replaces the reference. The next disagreement sets stable_err and returns busy to 0 without any buf_done. stable_err stays 1 until the next accepted start.
- R8: Each read is a single-cycle rd_en, and its rd_data is taken on the following cycle. rd_addr is the buf_last_addr captured at the accepted start, and it is held for the whole run. rd_en is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms a new run when idle |
| use_flag | input | 1 | 0 = sentinel mode, 1 = flag mode; sampled at start |
| ready_flag | input | 1 | External buffer-ready bit used in flag mode |
| buf_last_addr | input | ADDR_W | Address of the buffer's final word; sampled at start |
| rd_en | output | 1 | Read request to the shared RAM |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | DATA_W | Read data, valid the cycle after rd_en |
| buf_done | output | 1 | One-cycle pulse: buffer complete, stable_val valid |
| stable_val | output | DATA_W | Confirmed value of the final word |
| busy | output | 1 | A run is in progress |
| stable_err | output | 1 | Confirmation budget exceeded; held until next start |
| rearm_req | output | 1 | Request to write the sentinel back (sentinel mode) |

## Verification
The bench builds the block with DATA_W=16, ADDR_W=10, SENTINEL=16'hA5A5 and MAX_RETRY=3. This small retry budget makes both sides of the limit reachable in a few reads. One run has exactly three disagreements and still completes; another has four and raises the error. The 16-bit marker lets the bench script a torn word that shares its low byte with the marker and must still count as a change. The bench RAM model hands out a scripted value for each read, so it knows the exact number of reads each run should take.

// File: rtl/bufhs_pkg.sv
package bufhs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_POLL    = 2'd1,
    ST_CONFIRM = 2'd2,
    ST_DONE    = 2'd3
  } bufhs_state_e;

  // True when a disagreement arriving after miss_cnt earlier ones exceeds the budget.
  function automatic logic retry_exhausted(input int miss_cnt, input int budget);
    return miss_cnt >= budget;
  endfunction

endpackage

// File: rtl/bufhs_read_port.sv
module bufhs_read_port #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              active,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sample
);

  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;

  // Alternate issue and capture cycles while active.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else begin
      if (load) addr_q <= addr_in;
      pend_q <= active ? ~pend_q : 1'b0;
    end
  end

  assign rd_en   = active & ~pend_q;
  assign sample  = active & pend_q;
  assign rd_addr = addr_q;

endmodule

// File: rtl/bufhs_stable_cmp.sv
module bufhs_stable_cmp
  import bufhs_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_RETRY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load_first,
  input  logic              compare,
  input  logic [DATA_W-1:0] rd_data,
  output logic              agree,
  output logic              mismatch,
  output logic              exhausted
);

  localparam int CNT_W = $clog2(MAX_RETRY + 1);

  logic [DATA_W-1:0] ref_q;
  logic [CNT_W-1:0]  miss_q;

  function automatic logic same_word(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return a == b;
  endfunction

  assign agree     = compare & same_word(rd_data, ref_q);
  assign mismatch  = compare & ~same_word(rd_data, ref_q);
  assign exhausted = mismatch & retry_exhausted(int'(miss_q), MAX_RETRY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      miss_q <= '0;
    end else begin
      if (clear) miss_q <= '0;
      else if (mismatch && !exhausted) miss_q <= miss_q + 1'b1;
      if (load_first || mismatch) ref_q <= rd_data;
    end
  end

endmodule

// File: rtl/bufhs_ctrl.sv
module bufhs_ctrl
  import bufhs_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                ADDR_W    = 10,
  parameter int                MAX_RETRY = 3,
  parameter logic [DATA_W-1:0] SENTINEL  = 16'hA5A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              use_flag,
  input  logic              ready_flag,
  input  logic [ADDR_W-1:0] buf_last_addr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              buf_done,
  output logic [DATA_W-1:0] stable_val,
  output logic              busy,
  output logic              stable_err,
  output logic              rearm_req
);

  bufhs_state_e      st_q, st_d;
  logic              mode_q, need_first_q, err_q, rearm_q;
  logic [DATA_W-1:0] val_q;

  // Named internal events used by the checker.
  logic in_poll, in_conf, start_acc, wait_flag, active, sample;
  logic changed, load_first, compare, agree_ev, mismatch_ev, fail_ev;

  function automatic logic word_changed(input logic [DATA_W-1:0] w);
    return w != SENTINEL;
  endfunction

  assign in_poll    = (st_q == ST_POLL);
  assign in_conf    = (st_q == ST_CONFIRM);
  assign start_acc  = start & (st_q == ST_IDLE);
  assign wait_flag  = in_poll & mode_q;
  assign active     = (in_poll & ~mode_q) | in_conf;
  assign changed    = sample & word_changed(rd_data);
  assign load_first = (in_poll & ~mode_q & changed) | (in_conf & sample & need_first_q);
  assign compare    = in_conf & sample & ~need_first_q;

  bufhs_read_port #(.ADDR_W(ADDR_W)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_acc),
    .addr_in (buf_last_addr),
    .active  (active),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .sample  (sample)
  );

  bufhs_stable_cmp #(.DATA_W(DATA_W), .MAX_RETRY(MAX_RETRY)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_acc),
    .load_first (load_first),
    .compare    (compare),
    .rd_data    (rd_data),
    .agree      (agree_ev),
    .mismatch   (mismatch_ev),
    .exhausted  (fail_ev)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (start_acc) st_d = ST_POLL;
      ST_POLL:    if (mode_q ? ready_flag : changed) st_d = ST_CONFIRM;
      ST_CONFIRM: begin
        if (agree_ev)     st_d = ST_DONE;
        else if (fail_ev) st_d = ST_IDLE;
      end
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      mode_q       <= 1'b0;
      need_first_q <= 1'b0;
      err_q        <= 1'b0;
      rearm_q      <= 1'b0;
      val_q        <= '0;
    end else begin
      st_q    <= st_d;
      rearm_q <= start_acc & ~use_flag;
      if (start_acc) begin
        mode_q       <= use_flag;
        err_q        <= 1'b0;
        need_first_q <= 1'b0;
      end else if (wait_flag && ready_flag) begin
        need_first_q <= 1'b1;
      end else if (in_conf && sample) begin
        need_first_q <= 1'b0;
      end
      if (agree_ev) val_q <= rd_data;
      if (fail_ev)  err_q <= 1'b1;
    end
  end

  assign buf_done   = (st_q == ST_DONE);
  assign busy       = (st_q != ST_IDLE);
  assign stable_err = err_q;
  assign rearm_req  = rearm_q;
  assign stable_val = val_q;

endmodule

// File: rtl/bufhs_ctrl_chk.sv
module bufhs_ctrl_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              buf_done,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              stable_err,
  input logic              rearm_req,
  input logic              agree_ev,
  input logic              wait_flag
);

  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_rearm_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_req |-> $past(start && !busy));

  p_flag_wait_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_flag |-> !rd_en);

  p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |=> !buf_done);

  p_done_after_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |-> $past(agree_ev));

  p_err_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable_err) |-> (!buf_done && !busy));

  p_idle_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_en);

  p_addr_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_addr));

endmodule

bind bufhs_ctrl bufhs_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .buf_done   (buf_done),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .stable_err (stable_err),
  .rearm_req  (rearm_req),
  .agree_ev   (agree_ev),
  .wait_flag  (wait_flag)
);

// File: tb/bufhs_ctrl_tb_top.sv
module bufhs_ctrl_tb_top;

  localparam int          DW        = 16;
  localparam int          AW        = 10;
  localparam logic [15:0] SENT      = 16'hA5A5;
  localparam logic [9:0]  LAST_ADDR = 10'h2F3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          use_flag = 1'b0;
  logic          ready_flag = 1'b0;
  logic [AW-1:0] buf_last_addr = LAST_ADDR;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic          buf_done;
  logic [DW-1:0] stable_val;
  logic          busy;
  logic          stable_err;
  logic          rearm_req;

  always #10 clk = ~clk;

  bufhs_ctrl #(.DATA_W(DW), .ADDR_W(AW), .MAX_RETRY(3), .SENTINEL(SENT)) dut_i (
    .clk, .rst_n, .start, .use_flag, .ready_flag, .buf_last_addr,
    .rd_en, .rd_addr, .rd_data, .buf_done, .stable_val, .busy, .stable_err, .rearm_req
  );

  typedef struct {
    bit          err;
    logic [15:0] val;
    int          reads;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  int          n_chk = 0;
  int          n_err = 0;
  int          n_reads = 0;
  int          case_base = 0;
  int          addr_bad = 0;
  int          script_len = 0;
  logic [15:0] script_arr [0:15];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Shared RAM model: one cycle read latency, scripted value per read.
  always @(posedge clk) begin
    if (rd_en) begin
      int idx;
      idx = n_reads - case_base;
      if (rd_addr != LAST_ADDR) addr_bad++;
      rd_data <= (idx < script_len) ? script_arr[idx] : SENT;
      n_reads++;
    end
  end

  // Monitor: pop expected outcome on completion or error.
  bit done_prev = 1'b0;
  bit err_prev  = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_prev) chk(!buf_done, "R6", "buf_done single cycle", 32'(buf_done), 0);
      if (buf_done || (stable_err && !err_prev)) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(stable_err == e.err, e.req, "error flag", 32'(stable_err), 32'(e.err));
          if (!e.err) chk(stable_val == e.val, e.req, "stable_val", 32'(stable_val), 32'(e.val));
          chk((n_reads - case_base) == e.reads, "R8", "read count", 32'(n_reads - case_base), 32'(e.reads));
        end
      end
      done_prev = buf_done;
      err_prev  = stable_err;
    end
  end

  task automatic run_case(input bit m, input logic [15:0] vals[$], input bit exp_err,
                          input logic [15:0] exp_val, input bit extra_start, input string req);
    exp_t e;
    @(negedge clk);
    case_base  = n_reads;
    script_len = vals.size();
    foreach (vals[i]) script_arr[i] = vals[i];
    e.err = exp_err; e.val = exp_val; e.reads = vals.size(); e.req = req;
    sb_q.push_back(e);
    use_flag = m;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", 32'(busy), 1);
    chk(rearm_req == ~m, "R3", "rearm_req after start", 32'(rearm_req), 32'(~m));
    chk(stable_err == 1'b0, "R7", "err cleared by start", 32'(stable_err), 0);
    if (m) begin
      repeat (20) @(negedge clk);
      chk((n_reads - case_base) == 0, "R5", "no reads while flag low", 32'(n_reads - case_base), 0);
      ready_flag = 1'b1;
    end
    if (extra_start) begin
      repeat (3) @(negedge clk);
      use_flag = 1'b1;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(rearm_req == 1'b0, "R2", "start while busy ignored", 32'(rearm_req), 0);
      chk(busy == 1'b1, "R4", "still polling sentinel", 32'(busy), 1);
    end
    while (busy) @(negedge clk);
    ready_flag = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=expired expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && buf_done == 0 && rd_en == 0 && stable_err == 0 && rearm_req == 0,
        "R1", "outputs in reset", 32'({busy, buf_done, rd_en, stable_err, rearm_req}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && buf_done == 0 && rd_en == 0 && stable_err == 0 && rearm_req == 0,
        "R1", "outputs after reset", 32'({busy, buf_done, rd_en, stable_err, rearm_req}), 0);

    // R4/R6: sentinel seen twice, then a stable value.
    run_case(1'b0, '{SENT, SENT, 16'h1234, 16'h1234}, 1'b0, 16'h1234, 1'b0, "R4");
    // R4: torn word sharing the marker's low byte still counts as changed; R7 one retry.
    run_case(1'b0, '{SENT, 16'h12A5, 16'h1234, 16'h1234}, 1'b0, 16'h1234, 1'b0, "R7");
    // R7 boundary: exactly MAX_RETRY (3) disagreements, then agreement.
    run_case(1'b0, '{16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0004}, 1'b0, 16'h0004, 1'b0, "R7");
    // R7: a fourth disagreement raises the error.
    run_case(1'b0, '{16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0005}, 1'b1, 16'h0000, 1'b0, "R7");
    repeat (5) @(negedge clk);
    chk(stable_err == 1'b1, "R7", "error held while idle", 32'(stable_err), 1);
    chk(buf_done == 1'b0 && busy == 1'b0, "R7", "idle after error", 32'({buf_done, busy}), 0);
    // R5: flag mode, immediate agreement.
    run_case(1'b1, '{16'h0BEE, 16'h0BEE}, 1'b0, 16'h0BEE, 1'b0, "R5");
    // R5/R6: flag mode with one disagreement.
    run_case(1'b1, '{16'h1111, 16'h2222, 16'h2222}, 1'b0, 16'h2222, 1'b0, "R6");
    // R2: start while busy ignored during a long sentinel poll.
    run_case(1'b0, '{SENT, SENT, SENT, SENT, SENT, SENT, 16'h0042, 16'h0042}, 1'b0, 16'h0042, 1'b1, "R2");

    chk(addr_bad == 0, "R8", "read address", 32'(addr_bad), 0);
    chk(sb_q.size() == 0, "R6", "all outcomes observed", 32'(sb_q.size()), 0);
    finish_run();
  end

endmodule